// File: doc/BRIEF.md
# Envelope Compression and Level Mapping Channel

This block is one channel of the back end of an interleaved-pulse sound processor for an auditory implant. It takes band-pass filtered signed samples and rectifies them. It smooths the rectified stream into an envelope and keeps one envelope value out of every `DEC_N` accepted samples, which gives a 1 kHz analysis rate for a 16 kHz input. Each kept value goes through a global gain in power-of-two steps and a logarithmic compression law picked from three strengths. The compressed value is then scaled into the window between the channel's threshold and comfort levels.

The result is a 6-bit stimulation amplitude with a one-cycle valid strobe. A stimulator uses this value to set the current of the pulses for the matching electrode. A silent band gives zero so that no pulse is delivered. The configuration inputs are meant to stay static while a channel is running.

Top module: `cis_env_map_channel`

## Requirements
- R1: With `cfg_half_wave`=0 each sample is replaced by its magnitude, and the most negative code gives 2^(IN_W-1). With `cfg_half_wave`=1 negative samples become 0 and non-negative samples pass unchanged.
- R2: The envelope is 0 after reset. On each accepted sample (`in_valid`=1) it becomes e + ((r − e) >>> 4), where r is the rectified value and the shift is arithmetic, rounding toward minus infinity.
- R3: The envelope never exceeds 2^(IN_W-1).
- R4: Each time the number of accepted samples since reset reaches a multiple of `DEC_N`, `out_valid` is high for exactly one cycle. If that sample is taken at rising edge k, `out_valid` is high between edges k+3 and k+4, and `out_level` is derived from the envelope that includes that sample.
- R5: The kept envelope is shifted left by `cfg_gain` (0 to 7) and saturates at 2^IN_W − 1. The compression index i is bits [IN_W-1:IN_W-6] of that result.
- R6: `cfg_comp` code 0 selects c=500, code 1 selects c=128, and codes 2 and 3 select c=16. The compressed value is y = round(63·ln(1 + c·i/63) / ln(1 + c)).
- R7: With T = 8·`cfg_thr` and M = 8·`cfg_mcl`, the output is T + (((M − T)·y) >> 6) when `cfg_mcl` ≥ `cfg_thr`, and T otherwise.
- R8: A kept envelope of exactly 0 gives an output of 0. This rule takes precedence over R7.
- R9: After reset `out_valid` and `out_level` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A band-pass sample is present |
| in_sample | input | IN_W | Signed two's-complement band sample |
| cfg_half_wave | input | 1 | 1 selects half-wave rectification, 0 selects full-wave |
| cfg_gain | input | 3 | Left-shift amount for the global gain |
| cfg_comp | input | 2 | Compression strength code |
| cfg_thr | input | 3 | Threshold level of the channel |
| cfg_mcl | input | 3 | Comfort level of the channel |
| out_valid | output | 1 | Strobe marking a new amplitude |
| out_level | output | 6 | Stimulation amplitude |

## Verification
Two mapping rules can apply to the same output value. One is the zero-envelope rule. The other is the fallback to the threshold level when the comfort setting is below the threshold. The bench provokes both at once by feeding an all-zero band with `cfg_mcl` < `cfg_thr`, and it expects 0, not 8·`cfg_thr`. A second coincidence occurs on every kept sample: the decimation latch fires on the same edge that the smoother already takes the next sample. The bench models the envelope cycle by cycle and compares every output position and value, so a latch that is one sample early or late shows up as a value mismatch.

// File: rtl/cis_env_pkg.sv
// Package: shared constants and the compression table builder for the
// envelope channel. Assumes a 6-bit compression index and 6-bit output.
package cis_env_pkg;
    localparam int IDX_W  = 6;
    localparam int LVL_W  = 6;
    localparam int LUT_N  = 1 << IDX_W;
    localparam int LUT_BITS = LUT_N * LVL_W;

    typedef enum logic [1:0] {
        COMP_HEAVY  = 2'd0,
        COMP_MEDIUM = 2'd1,
        COMP_LIGHT  = 2'd2,
        COMP_SPARE  = 2'd3
    } comp_law_e;

    // Build a packed table: entry i = round(63*ln(1+c*i/63)/ln(1+c))
    function automatic logic [LUT_BITS-1:0] build_log_lut(input real c);
        logic [LUT_BITS-1:0] t;
        real full;
        real v;
        t = '0;
        full = real'(LUT_N - 1);
        for (int i = 0; i < LUT_N; i++) begin
            v = full * $ln(1.0 + c * real'(i) / full) / $ln(1.0 + c);
            t[i*LVL_W +: LVL_W] = LVL_W'($rtoi(v + 0.5));
        end
        return t;
    endfunction
endpackage

// File: rtl/cis_env_smoother.sv
// Rectifier and first-order envelope smoother.
// Assumes signed two's-complement input of IN_W bits; envelope is unsigned
// IN_W bits and is updated once per accepted sample.
module cis_env_smoother #(
    parameter int IN_W = 12,
    parameter int SHIFT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_sample,
    input  logic                   half_wave,
    output logic [IN_W-1:0]        env,
    output logic                   env_upd
);
    localparam logic [IN_W-1:0] MAX_MAG = IN_W'(1) << (IN_W - 1);

    logic [IN_W-1:0]   rect;
    logic signed [IN_W:0] diff;
    logic signed [IN_W:0] step;
    logic signed [IN_W:0] env_sum;

    // Rectify: magnitude or clamp negatives to zero
    always_comb begin
        if (in_sample[IN_W-1]) rect = half_wave ? '0 : (~in_sample + 1'b1);
        else                   rect = in_sample;
    end

    // Move envelope a fraction of the way toward the rectified value
    always_comb begin
        diff    = $signed({1'b0, rect}) - $signed({1'b0, env});
        step    = diff >>> SHIFT;
        env_sum = $signed({1'b0, env}) + step;
    end

    // Envelope register and update strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            env     <= '0;
            env_upd <= 1'b0;
        end else begin
            env_upd <= in_valid;
            if (in_valid) env <= env_sum[IN_W-1:0];
        end
    end

    assert_env_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        env <= MAX_MAG);

    assert_half_no_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && half_wave && in_sample[IN_W-1]) |=> env <= $past(env));
endmodule

// File: rtl/cis_env_decimator.sv
// Keeps one envelope value out of every DEC_N updates.
// Assumes DEC_N >= 2; emits a one-cycle strobe with the held value.
module cis_env_decimator #(
    parameter int IN_W  = 12,
    parameter int DEC_N = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            env_upd,
    input  logic [IN_W-1:0] env,
    output logic [IN_W-1:0] held,
    output logic            held_v
);
    localparam int CNT_W = (DEC_N > 2) ? $clog2(DEC_N) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEC_N - 1);

    logic [CNT_W-1:0] cnt;

    // Count updates and latch the value on the last one of each group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            held   <= '0;
            held_v <= 1'b0;
        end else begin
            held_v <= 1'b0;
            if (env_upd) begin
                if (cnt == LAST) begin
                    cnt    <= '0;
                    held   <= env;
                    held_v <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        held_v |=> !held_v);

    assert_strobe_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        held_v |-> $past(env_upd));
endmodule

// File: rtl/cis_env_compress.sv
// Octave gain with saturation followed by table-based log compression.
// Assumes IN_W >= IDX_W; flags an exact-zero input for the mapper.
module cis_env_compress
    import cis_env_pkg::*;
#(
    parameter int IN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             held_v,
    input  logic [IN_W-1:0]  held,
    input  logic [2:0]       gain,
    input  logic [1:0]       comp,
    output logic [LVL_W-1:0] comp_y,
    output logic             comp_zero,
    output logic             comp_v
);
    localparam int WIDE_W = IN_W + 7;
    localparam logic [WIDE_W-1:0] FULL = WIDE_W'((1 << IN_W) - 1);
    localparam logic [LUT_BITS-1:0] LUT_HEAVY  = build_log_lut(500.0);
    localparam logic [LUT_BITS-1:0] LUT_MEDIUM = build_log_lut(128.0);
    localparam logic [LUT_BITS-1:0] LUT_LIGHT  = build_log_lut(16.0);

    logic [WIDE_W-1:0] wide;
    logic [IN_W-1:0]   gained;
    logic [IDX_W-1:0]  idx;
    logic [LVL_W-1:0]  y;
    comp_law_e         law;

    // Shift by the gain and clip at full scale
    always_comb begin
        wide   = {7'b0, held} << gain;
        gained = (wide > FULL) ? FULL[IN_W-1:0] : wide[IN_W-1:0];
        idx    = gained[IN_W-1 -: IDX_W];
    end

    // Pick the table entry of the selected law
    always_comb begin
        law = comp_law_e'(comp);
        case (law)
            COMP_HEAVY:  y = LUT_HEAVY[idx*LVL_W +: LVL_W];
            COMP_MEDIUM: y = LUT_MEDIUM[idx*LVL_W +: LVL_W];
            default:     y = LUT_LIGHT[idx*LVL_W +: LVL_W];
        endcase
    end

    // Register the compressed value with its zero flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comp_y    <= '0;
            comp_zero <= 1'b0;
            comp_v    <= 1'b0;
        end else begin
            comp_v <= held_v;
            if (held_v) begin
                comp_y    <= y;
                comp_zero <= (held == '0);
            end
        end
    end

    assert_zero_in_zero_y_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (held_v && held == '0) |=> comp_y == '0);
endmodule

// File: rtl/cis_env_mapper.sv
// Scales the compressed value into the threshold-to-comfort window.
// Assumes 3-bit fitting levels scaled by 8 into the 6-bit output range.
module cis_env_mapper
    import cis_env_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             comp_v,
    input  logic [LVL_W-1:0] comp_y,
    input  logic             comp_zero,
    input  logic [2:0]       thr,
    input  logic [2:0]       mcl,
    output logic [LVL_W-1:0] level,
    output logic             level_v
);
    logic [LVL_W-1:0]     t_lvl;
    logic [LVL_W-1:0]     m_lvl;
    logic [2*LVL_W-1:0]   prod;
    logic [LVL_W-1:0]     mapped;

    // Place y inside the fitted window
    always_comb begin
        t_lvl = {thr, 3'b000};
        m_lvl = {mcl, 3'b000};
        prod  = (2*LVL_W)'(m_lvl - t_lvl) * (2*LVL_W)'(comp_y);
        if (comp_zero)       mapped = '0;
        else if (mcl < thr)  mapped = t_lvl;
        else                 mapped = t_lvl + prod[2*LVL_W-1:LVL_W][LVL_W-1:0];
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= '0;
            level_v <= 1'b0;
        end else begin
            level_v <= comp_v;
            if (comp_v) level <= mapped;
        end
    end

    assert_zero_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_v && comp_zero) |=> (level_v && level == '0));

    assert_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
        level_v |-> level <= 6'd56);

    assert_pipe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level_v |-> $past(comp_v));
endmodule

// File: rtl/cis_env_map_channel.sv
// Top: one channel from band sample to 6-bit stimulation amplitude.
// Assumes configuration is static while samples flow; DEC_N >= 2.
module cis_env_map_channel #(
    parameter int IN_W  = 12,
    parameter int DEC_N = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_sample,
    input  logic                   cfg_half_wave,
    input  logic [2:0]             cfg_gain,
    input  logic [1:0]             cfg_comp,
    input  logic [2:0]             cfg_thr,
    input  logic [2:0]             cfg_mcl,
    output logic                   out_valid,
    output logic [5:0]             out_level
);
    logic [IN_W-1:0] env;
    logic            env_upd;
    logic [IN_W-1:0] held;
    logic            held_v;
    logic [5:0]      comp_y;
    logic            comp_zero;
    logic            comp_v;

    cis_env_smoother #(.IN_W(IN_W), .SHIFT(4)) u_smooth (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .half_wave(cfg_half_wave), .env(env), .env_upd(env_upd));

    cis_env_decimator #(.IN_W(IN_W), .DEC_N(DEC_N)) u_dec (
        .clk(clk), .rst_n(rst_n), .env_upd(env_upd), .env(env),
        .held(held), .held_v(held_v));

    cis_env_compress #(.IN_W(IN_W)) u_comp (
        .clk(clk), .rst_n(rst_n), .held_v(held_v), .held(held),
        .gain(cfg_gain), .comp(cfg_comp), .comp_y(comp_y),
        .comp_zero(comp_zero), .comp_v(comp_v));

    cis_env_mapper u_map (
        .clk(clk), .rst_n(rst_n), .comp_v(comp_v), .comp_y(comp_y),
        .comp_zero(comp_zero), .thr(cfg_thr), .mcl(cfg_mcl),
        .level(out_level), .level_v(out_valid));
endmodule

// File: tb/cis_env_map_channel_test.sv
`timescale 1ns/1ps
module cis_env_map_channel_test;
    localparam int IN_W  = 12;
    localparam int DEC_N = 16;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic signed [IN_W-1:0] in_sample = '0;
    logic                   cfg_half_wave = 1'b0;
    logic [2:0]             cfg_gain = 3'd0;
    logic [1:0]             cfg_comp = 2'd0;
    logic [2:0]             cfg_thr = 3'd0;
    logic [2:0]             cfg_mcl = 3'd7;
    logic                   out_valid;
    logic [5:0]             out_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench-side model state
    int m_env, m_cnt;
    int pv[4];
    int pl[4];

    cis_env_map_channel #(.IN_W(IN_W), .DEC_N(DEC_N)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_half_wave(cfg_half_wave), .cfg_gain(cfg_gain), .cfg_comp(cfg_comp),
        .cfg_thr(cfg_thr), .cfg_mcl(cfg_mcl), .out_valid(out_valid),
        .out_level(out_level));

    always #4 clk = ~clk;

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int lut_val(input int code, input int i);
        real c, v;
        c = (code == 0) ? 500.0 : (code == 1) ? 128.0 : 16.0;
        v = 63.0 * $ln(1.0 + c * real'(i) / 63.0) / $ln(1.0 + c);
        return $rtoi(v + 0.5);
    endfunction

    // Kept envelope to output level per R5..R8
    function automatic int map_level(input int e);
        int g, idx, y, t, m;
        if (e == 0) return 0;
        g = e << cfg_gain;
        if (g > 4095) g = 4095;
        idx = g >> (IN_W - 6);
        y = lut_val(cfg_comp, idx);
        t = 8 * cfg_thr;
        m = 8 * cfg_mcl;
        if (cfg_mcl < cfg_thr) return t;
        return t + (((m - t) * y) >> 6);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_env = 0; m_cnt = 0;
        for (int k = 0; k < 4; k++) begin pv[k] = 0; pl[k] = 0; end
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit v, input int s, input string req);
        int r, ev, el;
        in_valid = v;
        in_sample = IN_W'(s);
        @(posedge clk);
        ev = 0; el = 0;
        if (v) begin
            if (s < 0) r = cfg_half_wave ? 0 : -s;
            else       r = s;
            m_env = m_env + ((r - m_env) >>> 4);
            m_cnt++;
            if (m_cnt == DEC_N) begin
                m_cnt = 0;
                ev = 1;
                el = map_level(m_env);
            end
        end
        @(negedge clk);
        pv[3] = pv[2]; pl[3] = pl[2];
        pv[2] = pv[1]; pl[2] = pl[1];
        pv[1] = pv[0]; pl[1] = pl[0];
        pv[0] = ev;    pl[0] = el;
        check({req, " R4 strobe"}, int'(out_valid), pv[3]);
        if (pv[3] != 0) check({req, " level"}, int'(out_level), pl[3]);
    endtask

    // Feed n samples of a sawtooth spanning -amp..amp (kind 0) or a constant (kind 1)
    task automatic run(input string req, input int kind, input int amp, input int n);
        int s;
        for (int i = 0; i < n; i++) begin
            if (kind == 0) s = ((i * 97) % (2 * amp + 1)) - amp;
            else           s = amp;
            if (s > 2047) s = 2047;
            if (s < -2048) s = -2048;
            step(1'b1, s, req);
        end
        for (int i = 0; i < 5; i++) step(1'b0, 0, req);
    endtask

    task automatic cfg(input bit h, input int g, input int c, input int t, input int m);
        cfg_half_wave = h; cfg_gain = 3'(g); cfg_comp = 2'(c);
        cfg_thr = 3'(t); cfg_mcl = 3'(m);
    endtask

    task automatic t_reset();
        do_reset();
        check("R9 out_valid after reset", int'(out_valid), 0);
        check("R9 out_level after reset", int'(out_level), 0);
    endtask

    task automatic t_full_wave();
        cfg(0, 2, 0, 1, 6); do_reset();
        run("R1 R2 R6 full-wave c=500", 0, 1500, 8 * DEC_N);
    endtask

    task automatic t_half_wave();
        cfg(1, 2, 0, 1, 6); do_reset();
        run("R1 half-wave", 0, 1500, 8 * DEC_N);
        run("R1 half-wave negative only", 1, -900, 3 * DEC_N);
    endtask

    task automatic t_gain_sat();
        cfg(0, 7, 1, 0, 7); do_reset();
        run("R5 gain saturation", 1, 1800, 6 * DEC_N);
        cfg(0, 0, 1, 0, 7); do_reset();
        run("R5 unity gain", 1, 300, 6 * DEC_N);
    endtask

    task automatic t_laws();
        cfg(0, 3, 1, 2, 7); do_reset();
        run("R6 c=128", 0, 800, 6 * DEC_N);
        cfg(0, 3, 2, 2, 7); do_reset();
        run("R6 c=16", 0, 800, 6 * DEC_N);
        cfg(0, 3, 3, 2, 7); do_reset();
        run("R6 code3 as c=16", 0, 800, 6 * DEC_N);
    endtask

    task automatic t_inverted();
        cfg(0, 1, 0, 5, 2); do_reset();
        run("R7 mcl below thr", 0, 1200, 4 * DEC_N);
        cfg(0, 1, 0, 3, 3); do_reset();
        run("R7 equal levels", 0, 1200, 4 * DEC_N);
    endtask

    task automatic t_zero();
        cfg(0, 7, 0, 6, 1); do_reset();
        run("R8 zero band with inverted fit", 1, 0, 4 * DEC_N);
    endtask

    task automatic t_extreme();
        cfg(0, 0, 0, 0, 7); do_reset();
        run("R3 most-negative full-wave", 1, -2048, 20 * DEC_N);
        check("R3 model envelope bound", int'(m_env <= 2048), 1);
    endtask

    initial begin
        t_reset();
        t_full_wave();
        t_half_wave();
        t_gain_sat();
        t_laws();
        t_inverted();
        t_zero();
        t_extreme();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule